// File: doc/BRIEF.md
# DMA Channel Interrupt and Enable Register Block

This block is the register-side control of a small multi-channel DMA engine. The datapath reports five kinds of per-channel event as single-cycle pulses: transfer done, block done, source transaction, destination transaction and error. For each kind the block keeps a sticky raw bit per channel, a per-channel mask, a masked status view and a write-one-to-clear view. It also drives one combined interrupt line.

The block also holds the global engine enable and the per-channel enable register. The datapath sees the effective run vector. Software treats a set channel-enable bit as "channel busy". The hardware drops that bit when the channel reports transfer done or error. Mask and channel-enable writes carry per-bit write-enable lanes in bits [8 +: channels]. Software can therefore start, stop, mask or unmask one channel without a read-modify-write.

Access goes through a simple word-addressed register port. Read data is registered and appears on the cycle after the read request.

Top module: `dma_irq_regs`

## Requirements
- R1: A synchronous active-high reset clears the global enable, all channel-enable bits, all raw bits, all mask bits, the read data and `irq`.
- R2: A pulse on bit ch of an event input sets raw bit ch of that event kind, and the bit stays set. Event kinds are numbered xfer=0, block=1, src=2, dst=3, err=4. The raw view of kind e is read at word address 16+4e.
- R3: Writing the clear view (address 16+4e+3) with bit ch set clears raw bit ch of kind e. If an event pulse arrives in the same cycle, the bit stays set.
- R4: The status view (address 16+4e+1) reads raw AND mask. The summary register (address 2) has bit e set when any status bit of kind e is set.
- R5: A write to the mask view (address 16+4e+2) changes mask bit ch only when bit ch+8 of the written word is set. The new value is bit ch. All other mask bits are unchanged.
- R6: A write to the channel-enable register (address 1) changes bit ch only when bit ch+8 is set. The register reads back as the busy set.
- R7: Bit 0 of the configuration register (address 0) is the global enable. `ch_run` equals the channel-enable bits gated by it, and `dma_on` reflects it.
- R8: A transfer-done or error pulse on channel ch clears channel-enable bit ch. A lane-enabled software write to that bit in the same cycle takes precedence.
- R9: `irq` is high exactly when any masked status bit of any kind is set. It changes in the same cycle as the raw and mask state.
- R10: Read data is loaded only on a read access and is held otherwise. Bits 31:8 of mask and channel-enable reads are zero. Clear views and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ev_xfer | input | NUM_CH | Transfer-done pulses |
| ev_block | input | NUM_CH | Block-done pulses |
| ev_src | input | NUM_CH | Source transaction pulses |
| ev_dst | input | NUM_CH | Destination transaction pulses |
| ev_err | input | NUM_CH | Error pulses |
| irq | output | 1 | Combined interrupt |
| dma_on | output | 1 | Global enable |
| ch_run | output | NUM_CH | Channels permitted to run |

## Verification
The bench builds the block with NUM_CH=6 and ADDR_W=8. With six channels, the write-enable lanes 14 and 15 and the data bits 6 and 7 have no channel behind them. Writes there must leave no trace, and reads of them must return zero. The 8-bit address also reaches unmapped words above the event views. A cycle-accurate model covers the same-cycle collisions: clear against event pulse, and done pulse against software enable.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int NUM_EVT    = 5;
  localparam int EV_XFER    = 0;
  localparam int EV_BLOCK   = 1;
  localparam int EV_SRC     = 2;
  localparam int EV_DST     = 3;
  localparam int EV_ERR     = 4;
  localparam int WE_LSB     = 8;
  localparam int CFG_OFS    = 0;
  localparam int CHEN_OFS   = 1;
  localparam int SUM_OFS    = 2;
  localparam int EVT_BASE   = 16;
  localparam int EVT_STRIDE = 4;
  localparam int V_RAW      = 0;
  localparam int V_STAT     = 1;
  localparam int V_MASK     = 2;
  localparam int V_CLR      = 3;
endpackage

// File: rtl/dma_evt_bank.sv
module dma_evt_bank #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] ev,
  input  logic              mask_wr,
  input  logic              clr_wr,
  input  logic [NUM_CH-1:0] wr_val,
  input  logic [NUM_CH-1:0] wr_lane,
  output logic [NUM_CH-1:0] raw_q,
  output logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] raw_d,
  output logic [NUM_CH-1:0] mask_d
);
  always_comb begin
    // a new event wins over a clear in the same cycle
    raw_d = (raw_q & ~(clr_wr ? wr_val : '0)) | ev;
    for (int c = 0; c < NUM_CH; c++) begin
      mask_d[c] = (mask_wr && wr_lane[c]) ? wr_val[c] : mask_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
    end else begin
      raw_q  <= raw_d;
      mask_q <= mask_d;
    end
  end
endmodule

// File: rtl/dma_chan_en.sv
module dma_chan_en #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              chen_wr,
  input  logic              cfg_val,
  input  logic [NUM_CH-1:0] wr_val,
  input  logic [NUM_CH-1:0] wr_lane,
  input  logic [NUM_CH-1:0] done,
  output logic              glb_q,
  output logic [NUM_CH-1:0] chen_q
);
  logic [NUM_CH-1:0] chen_d;

  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (chen_wr && wr_lane[c]) chen_d[c] = wr_val[c];
      else if (done[c])          chen_d[c] = 1'b0;
      else                       chen_d[c] = chen_q[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_q  <= 1'b0;
      chen_q <= '0;
    end else begin
      if (cfg_wr) glb_q <= cfg_val;
      chen_q <= chen_d;
    end
  end
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] ev_xfer,
  input  logic [NUM_CH-1:0] ev_block,
  input  logic [NUM_CH-1:0] ev_src,
  input  logic [NUM_CH-1:0] ev_dst,
  input  logic [NUM_CH-1:0] ev_err,
  output logic              irq,
  output logic              dma_on,
  output logic [NUM_CH-1:0] ch_run
);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_OFS);
  localparam logic [ADDR_W-1:0] A_CHEN = ADDR_W'(CHEN_OFS);
  localparam logic [ADDR_W-1:0] A_SUM  = ADDR_W'(SUM_OFS);

  logic wr, rd;
  logic [NUM_CH-1:0] wr_val, wr_lane;
  logic [NUM_EVT-1:0][NUM_CH-1:0] ev_all, raw_q, mask_q, raw_d, mask_d;
  logic [NUM_EVT-1:0] hit_raw, hit_stat, hit_mask, hit_clr, evt_any;
  logic glb_q, irq_d, unused_wdata;
  logic [NUM_CH-1:0] chen_q;
  logic [31:0] rd_mux;

  assign wr           = reg_en && reg_we;
  assign rd           = reg_en && !reg_we;
  assign wr_val       = reg_wdata[NUM_CH-1:0];
  assign wr_lane      = reg_wdata[WE_LSB +: NUM_CH];
  assign unused_wdata = ^reg_wdata;

  assign ev_all[EV_XFER]  = ev_xfer;
  assign ev_all[EV_BLOCK] = ev_block;
  assign ev_all[EV_SRC]   = ev_src;
  assign ev_all[EV_DST]   = ev_dst;
  assign ev_all[EV_ERR]   = ev_err;

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_evt
    localparam int BASE = EVT_BASE + e * EVT_STRIDE;
    assign hit_raw[e]  = reg_addr == ADDR_W'(BASE + V_RAW);
    assign hit_stat[e] = reg_addr == ADDR_W'(BASE + V_STAT);
    assign hit_mask[e] = reg_addr == ADDR_W'(BASE + V_MASK);
    assign hit_clr[e]  = reg_addr == ADDR_W'(BASE + V_CLR);
    assign evt_any[e]  = |(raw_q[e] & mask_q[e]);

    dma_evt_bank #(.NUM_CH(NUM_CH)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .ev      (ev_all[e]),
      .mask_wr (wr && hit_mask[e]),
      .clr_wr  (wr && hit_clr[e]),
      .wr_val  (wr_val),
      .wr_lane (wr_lane),
      .raw_q   (raw_q[e]),
      .mask_q  (mask_q[e]),
      .raw_d   (raw_d[e]),
      .mask_d  (mask_d[e])
    );
  end

  dma_chan_en #(.NUM_CH(NUM_CH)) u_chen (
    .clk     (clk),
    .rst     (rst),
    .cfg_wr  (wr && reg_addr == A_CFG),
    .chen_wr (wr && reg_addr == A_CHEN),
    .cfg_val (reg_wdata[0]),
    .wr_val  (wr_val),
    .wr_lane (wr_lane),
    .done    (ev_xfer | ev_err),
    .glb_q   (glb_q),
    .chen_q  (chen_q)
  );

  assign dma_on = glb_q;
  assign ch_run = chen_q & {NUM_CH{glb_q}};

  always_comb begin
    irq_d = 1'b0;
    for (int e = 0; e < NUM_EVT; e++) irq_d = irq_d | (|(raw_d[e] & mask_d[e]));
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == A_CFG)       rd_mux[0] = glb_q;
    else if (reg_addr == A_CHEN) rd_mux[NUM_CH-1:0] = chen_q;
    else if (reg_addr == A_SUM)  rd_mux[NUM_EVT-1:0] = evt_any;
    for (int e = 0; e < NUM_EVT; e++) begin
      if (hit_raw[e])  rd_mux[NUM_CH-1:0] = raw_q[e];
      if (hit_stat[e]) rd_mux[NUM_CH-1:0] = raw_q[e] & mask_q[e];
      if (hit_mask[e]) rd_mux[NUM_CH-1:0] = mask_q[e];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      reg_rdata <= '0;
    end else begin
      irq <= irq_d;
      if (rd) reg_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/dma_irq_regs_chk.sv
module dma_irq_regs_chk
  import dma_irq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_en,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [31:0]       reg_rdata,
  input logic [NUM_CH-1:0] ev_xfer,
  input logic [NUM_CH-1:0] ev_block,
  input logic [NUM_CH-1:0] ev_src,
  input logic [NUM_CH-1:0] ev_dst,
  input logic [NUM_CH-1:0] ev_err,
  input logic              irq,
  input logic              dma_on,
  input logic [NUM_CH-1:0] ch_run
);
  logic chen_wr, cfg_wr, any_ev, mask_wr_any;
  logic [NUM_CH-1:0] done_v;

  assign chen_wr = reg_en && reg_we && reg_addr == ADDR_W'(CHEN_OFS);
  assign cfg_wr  = reg_en && reg_we && reg_addr == ADDR_W'(CFG_OFS);
  assign any_ev  = |{ev_xfer, ev_block, ev_src, ev_dst, ev_err};
  assign done_v  = ev_xfer | ev_err;

  always_comb begin
    mask_wr_any = 1'b0;
    for (int e = 0; e < NUM_EVT; e++)
      if (reg_en && reg_we && reg_addr == ADDR_W'(EVT_BASE + e * EVT_STRIDE + V_MASK))
        mask_wr_any = 1'b1;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq && ch_run == '0 && !dma_on)); // R1

  AST_RUN_GATED: assert property (@(posedge clk) disable iff (rst)
    (ch_run != '0) |-> dma_on); // R7

  AST_DONE_DROPS: assert property (@(posedge clk) disable iff (rst)
    ((done_v != '0) && !chen_wr) |=> ((ch_run & $past(done_v)) == '0)); // R8

  AST_RUN_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ((ch_run & ~$past(ch_run)) != '0)) |-> $past(chen_wr || cfg_wr)); // R6

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(irq)) |-> $past(any_ev || mask_wr_any)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(reg_en && !reg_we)) |-> $stable(reg_rdata)); // R10
endmodule

bind dma_irq_regs dma_irq_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .ev_xfer(ev_xfer), .ev_block(ev_block), .ev_src(ev_src),
  .ev_dst(ev_dst), .ev_err(ev_err), .irq(irq), .dma_on(dma_on), .ch_run(ch_run)
);

// File: tb/test_dma_irq_regs.sv
module test_dma_irq_regs;
  localparam int NCH = 6;
  localparam int AW  = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_en = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NCH-1:0] ev_xfer = '0, ev_block = '0, ev_src = '0, ev_dst = '0, ev_err = '0;
  logic irq, dma_on;
  logic [NCH-1:0] ch_run;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  logic [NCH-1:0] m_raw [5];
  logic [NCH-1:0] m_mask [5];
  logic [NCH-1:0] m_chen;
  logic m_glb, m_irq;
  logic [31:0] m_rdata;

  always #10 clk = ~clk;

  dma_irq_regs #(.NUM_CH(NCH), .ADDR_W(AW)) i_dma_irq_regs (
    .clk(clk), .rst(rst), .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_xfer(ev_xfer), .ev_block(ev_block),
    .ev_src(ev_src), .ev_dst(ev_dst), .ev_err(ev_err), .irq(irq), .dma_on(dma_on),
    .ch_run(ch_run)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input int a);
    logic [31:0] r = '0;
    if (a == 0) r[0] = m_glb;
    else if (a == 1) r[NCH-1:0] = m_chen;
    else if (a == 2) begin
      for (int e = 0; e < 5; e++) r[e] = |(m_raw[e] & m_mask[e]);
    end else if (a >= 16 && a < 36) begin
      case ((a - 16) % 4)
        0: r[NCH-1:0] = m_raw[(a - 16) / 4];
        1: r[NCH-1:0] = m_raw[(a - 16) / 4] & m_mask[(a - 16) / 4];
        2: r[NCH-1:0] = m_mask[(a - 16) / 4];
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic step(input logic en, input logic we, input int a, input logic [31:0] wd,
                      input logic [4:0][NCH-1:0] ev, input string tag);
    logic wrt;
    reg_en = en; reg_we = we; reg_addr = a[AW-1:0]; reg_wdata = wd;
    ev_xfer = ev[0]; ev_block = ev[1]; ev_src = ev[2]; ev_dst = ev[3]; ev_err = ev[4];
    wrt = en && we;
    if (en && !we) m_rdata = m_read(a);
    for (int e = 0; e < 5; e++) begin
      logic [NCH-1:0] clr;
      clr = (wrt && a == 16 + 4*e + 3) ? wd[NCH-1:0] : '0;
      m_raw[e] = (m_raw[e] & ~clr) | ev[e];
      for (int c = 0; c < NCH; c++)
        if (wrt && a == 16 + 4*e + 2 && wd[8+c]) m_mask[e][c] = wd[c];
    end
    for (int c = 0; c < NCH; c++) begin
      if (wrt && a == 1 && wd[8+c]) m_chen[c] = wd[c];
      else if (ev[0][c] || ev[4][c]) m_chen[c] = 1'b0;
    end
    if (wrt && a == 0) m_glb = wd[0];
    m_irq = 1'b0;
    for (int e = 0; e < 5; e++) m_irq = m_irq | (|(m_raw[e] & m_mask[e]));
    @(negedge clk);
    chk(tag, "irq", {31'd0, irq}, {31'd0, m_irq});
    chk(tag, "ch_run", {{(32-NCH){1'b0}}, ch_run}, {{(32-NCH){1'b0}}, m_chen & {NCH{m_glb}}});
    chk(tag, "dma_on", {31'd0, dma_on}, {31'd0, m_glb});
    chk(tag, "rdata", reg_rdata, m_rdata);
  endtask

  task automatic wr(input int a, input logic [31:0] d, input string tag);
    step(1'b1, 1'b1, a, d, '0, tag);
  endtask
  task automatic rd(input int a, input string tag);
    step(1'b1, 1'b0, a, 32'd0, '0, tag);
  endtask
  task automatic pulse(input int e, input logic [NCH-1:0] v, input string tag);
    logic [4:0][NCH-1:0] ev = '0;
    ev[e] = v;
    step(1'b0, 1'b0, 0, 32'd0, ev, tag);
  endtask

  initial begin
    for (int e = 0; e < 5; e++) begin m_raw[e] = '0; m_mask[e] = '0; end
    m_chen = '0; m_glb = 1'b0; m_irq = 1'b0; m_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: everything cleared after reset
    chk("R1", "irq", {31'd0, irq}, 32'd0);
    chk("R1", "ch_run", {{(32-NCH){1'b0}}, ch_run}, 32'd0);
    for (int a = 0; a < 36; a++) rd(a, "R1");
    // R7: global enable gates the run vector
    wr(0, 32'h1, "R7"); rd(0, "R7");
    wr(1, 32'h0000_0101, "R7");
    wr(0, 32'h0, "R7"); rd(1, "R7");
    wr(0, 32'h1, "R7");
    // R2: raw bits set by pulses and stay
    for (int e = 0; e < 5; e++) pulse(e, NCH'(1 << e), "R2");
    pulse(1, 6'b100000, "R2");
    for (int e = 0; e < 5; e++) rd(16 + 4*e, "R2");
    // R5: lane-gated mask writes
    wr(18, 32'h0000_0301, "R5");
    wr(18, 32'h0000_04FF, "R5"); rd(18, "R5");
    wr(18, 32'h0000_00FF, "R5"); rd(18, "R5");
    wr(22, 32'h0000_C0FF, "R5"); rd(22, "R5");
    // R4 / R9: status, summary, interrupt line
    rd(17, "R4"); rd(2, "R4");
    wr(34, 32'h0000_1010, "R9"); rd(33, "R4"); rd(2, "R4");
    // R3: clear, and clear colliding with a pulse
    wr(35, 32'h10, "R3"); rd(32, "R3");
    pulse(0, 6'b000001, "R3");
    wr(18, 32'h0000_0101, "R9");
    wr(19, 32'h1, "R3"); rd(16, "R3");
    step(1'b1, 1'b1, 19, 32'h4, {5{6'b000100}} & {24'd0, 6'b000100}, "R3");
    rd(16, "R3");
    // R6 / R8: channel enable, done/error clearing, collisions
    wr(1, 32'h0000_3F3F, "R6"); rd(1, "R6");
    pulse(0, 6'b000010, "R8"); rd(1, "R8");
    pulse(4, 6'b001000, "R8"); rd(1, "R8");
    step(1'b1, 1'b1, 1, 32'h0000_2020, {6'd0, 6'd0, 6'd0, 6'd0, 6'b100000}, "R8");
    rd(1, "R8");
    wr(1, 32'h0000_0100, "R6"); rd(1, "R6");
    wr(1, 32'h0000_C0C0, "R6"); rd(1, "R6");
    // R10: read-data width, unmapped, hold
    wr(26, 32'hFFFF_FFFF, "R10"); rd(26, "R10");
    rd(27, "R10"); rd(3, "R10"); rd(40, "R10"); rd(1, "R10");
    rd(24, "R10");
    step(1'b0, 1'b0, 0, 32'd0, '0, "R10");
    wr(0, 32'h1, "R10");
    // randomized traffic against the model
    for (int i = 0; i < 500; i++) begin
      logic [4:0][NCH-1:0] ev;
      int a;
      int pick;
      for (int e = 0; e < 5; e++) ev[e] = ($urandom % 6 == 0) ? NCH'($urandom) : '0;
      pick = $urandom % 8;
      if (pick < 2) a = $urandom % 3;
      else if (pick < 7) a = 16 + ($urandom % 20);
      else a = $urandom % 64;
      step($urandom % 3 != 0, $urandom % 2 == 0, a, $urandom, ev, "R4");
    end
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule